// File: doc/BRIEF.md
# DRAM Initialization and Refresh Scheduler

This block brings an asynchronous, multiplexed-address DRAM out of power-up and then keeps its contents alive. After reset it waits a fixed pause, measured in clock cycles derived from a clock-frequency parameter. It then asks the access sequencer for a burst of initialization refresh cycles. Once the burst is complete it signals readiness. From then on it raises a refresh request at an even spacing, so that every row is refreshed within the retention window.

The scheduler does not drive any DRAM pin. A request/grant handshake hands each refresh to the access sequencer, together with the refresh style to use. In the CAS-before-RAS style the device supplies its own row. In the RAS-only style the scheduler supplies the row from its own counter. While the sequencer is busy, owed refreshes accumulate up to a parameterized limit and are serviced back to back later. The pause is rounded up to whole cycles, and the refresh interval is rounded down.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset release, `ref_req` and `ready` stay low for exactly ceil(PAUSE_NS*CLK_MHZ/1000) cycles. `ref_req` rises at the clock edge that ends that count. Grants during the pause have no effect on any output.
- R2: After the pause, `ref_req` stays high until INIT_CYCLES grants have been accepted. Grants of either refresh style count toward this total.
- R3: `ready` rises after the clock edge that accepts the last initialization grant, and it stays high until reset.
- R4: Once `ready` is high, one refresh becomes owed every floor(RETENTION_US*CLK_MHZ/ROWS) cycles. The first one falls due that many cycles after `ready` rises.
- R5: A grant is accepted only in a cycle where `ref_grant` and `ref_req` are both high. A request stays high until it is granted, and a grant while `ref_req` is low has no effect.
- R6: Up to MAX_PENDING owed refreshes are held, and further ones are dropped once that limit is reached. `ref_req` stays high while any refresh is owed, and each accepted grant retires one. A refresh falling due in the same cycle as an accepted grant leaves the count unchanged.
- R7: `ref_row` is 0 after reset. It advances by one, wrapping from ROWS-1 to 0, on each accepted grant while `style_ras_only` is 1. Otherwise it holds.
- R8: `ref_cbr` is 1 exactly when `style_ras_only` is 0, combinationally in the same cycle.
- R9: While `rst_n` is low, `ref_req`, `ready` and `ref_row` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_MHZ megahertz |
| rst_n | input | 1 | Asynchronous active-low reset |
| style_ras_only | input | 1 | 1 selects RAS-only refresh with an external row, 0 selects CAS-before-RAS |
| ref_grant | input | 1 | Access sequencer takes the current refresh request |
| ref_req | output | 1 | A refresh is owed |
| ref_cbr | output | 1 | Refresh style to perform: 1 means CAS-before-RAS |
| ref_row | output | $clog2(ROWS) | Row address for a RAS-only refresh |
| ready | output | 1 | Pause and initialization burst complete |

## Verification
A wrong pause or interval count shows at the ports as a `ref_req` edge that comes a cycle early or late. The bench compares that edge against its own model on every clock, so the error is caught at the first misplaced edge. A corrupted owed-refresh count shows later, when a backlog is drained: `ref_req` falls after the wrong number of accepted grants. A wrong row step or wrap shows on `ref_row` in the cycle after the accepted grant. The bench steps the row past its wrap point, so a wrap fault is also caught.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;
endpackage

// File: rtl/drs_tick_timer.sv
module drs_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = tick ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4
endmodule

// File: rtl/drs_pending_ctr.sv
module drs_pending_ctr #(
  parameter int MAX_PENDING = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic any
);
  localparam int PW = $clog2(MAX_PENDING + 1);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PENDING);

  logic [PW-1:0] pend_q, pend_d;

  assign any = (pend_q != '0);

  always_comb begin
    pend_d = pend_q;
    if (inc && !dec && pend_q != PMAX) pend_d = pend_q + PW'(1);
    else if (dec && !inc)              pend_d = pend_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (inc || dec) pend_q <= pend_d;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PMAX); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !dec); // R5
endmodule

// File: rtl/drs_row_counter.sv
module drs_row_counter #(
  parameter int ROWS = 2048
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int RW = $clog2(ROWS);
  localparam logic [RW-1:0] TOP = RW'(ROWS - 1);

  logic [RW-1:0] row_q, row_d;

  assign row = row_q;

  always_comb begin
    row_d = (row_q == TOP) ? '0 : row_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else if (adv) row_q <= row_d;
  end

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (($past(row_q) == TOP) ? (row_q == '0) : (row_q == $past(row_q) + RW'(1)))); // R7
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(row_q)); // R7
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_MHZ      = 200,
  parameter int PAUSE_NS     = 200000,
  parameter int INIT_CYCLES  = 8,
  parameter int ROWS         = 2048,
  parameter int RETENTION_US = 32000,
  parameter int MAX_PENDING  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    style_ras_only,
  input  logic                    ref_grant,
  output logic                    ref_req,
  output logic                    ref_cbr,
  output logic [$clog2(ROWS)-1:0] ref_row,
  output logic                    ready
);
  import drs_pkg::*;

  // Minimum wait rounds up; maximum spacing rounds down.
  localparam int PAUSE_CYC = (PAUSE_NS * CLK_MHZ + 999) / 1000;
  localparam int IVAL_CYC  = (RETENTION_US * CLK_MHZ) / ROWS;
  localparam int IW        = $clog2(INIT_CYCLES + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

  phase_t        ph_q, ph_d;
  logic [IW-1:0] init_q, init_d;
  logic          pause_done, ival_tick, owed, accept;

  drs_tick_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(ph_q == PH_PAUSE), .tick(pause_done));

  drs_tick_timer #(.LIMIT(IVAL_CYC)) u_ival (
    .clk(clk), .rst_n(rst_n), .en(ph_q == PH_RUN), .tick(ival_tick));

  drs_pending_ctr #(.MAX_PENDING(MAX_PENDING)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(ival_tick), .dec(accept && ph_q == PH_RUN),
    .any(owed));

  drs_row_counter #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(accept && style_ras_only), .row(ref_row));

  assign ref_req = (ph_q == PH_INIT) || (ph_q == PH_RUN && owed);
  assign accept  = ref_req && ref_grant;
  assign ref_cbr = !style_ras_only;
  assign ready   = (ph_q == PH_RUN);

  always_comb begin
    ph_d   = ph_q;
    init_d = init_q;
    case (ph_q)
      PH_PAUSE: if (pause_done) ph_d = PH_INIT;
      PH_INIT: if (accept) begin
        if (init_q == INIT_LAST) ph_d = PH_RUN;
        else init_d = init_q + IW'(1);
      end
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_PAUSE;
      init_q <= '0;
    end else begin
      ph_q   <= ph_d;
      init_q <= init_d;
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_READY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(ref_req && ref_grant)); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant) |=> ref_req); // R5
  AST_STYLE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cbr != style_ras_only); // R8
endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int CLK_MHZ = 200;
  localparam int ROWS    = 16;
  localparam int MAXP    = 3;
  localparam int INITN   = 8;
  // 2003 ns at 200 MHz = 400.6 cycles, rounded up to 401 (R1)
  localparam int PAUSE_EXP = 401;
  // 63 us * 200 / 16 rows = 787.5 cycles, rounded down to 787 (R4)
  localparam int IVAL_EXP  = 787;

  logic       clk = 1'b0;
  logic       rst_n, style, grant;
  logic       req, cbr, rdy;
  logic [3:0] row;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_NS(2003), .INIT_CYCLES(INITN), .ROWS(ROWS),
    .RETENTION_US(63), .MAX_PENDING(MAXP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .style_ras_only(style), .ref_grant(grant),
    .ref_req(req), .ref_cbr(cbr), .ref_row(row), .ready(rdy));

  int checks = 0, errors = 0, cycles = 0;
  // reference model
  int m_phase, m_pcnt, m_icnt, m_tcnt, m_pend, m_row;
  int since_rel, first_req, ras_acc;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit m_req();
    return (m_phase == 1) || (m_phase == 2 && m_pend > 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic m_reset();
    m_phase = 0; m_pcnt = 0; m_icnt = 0; m_tcnt = 0; m_pend = 0; m_row = 0;
  endtask

  task automatic m_step(input bit g, input bit s);
    bit acc, tk;
    acc = g && m_req();
    if (acc && s) begin m_row = (m_row + 1) % ROWS; ras_acc++; end
    case (m_phase)
      0: if (m_pcnt == PAUSE_EXP - 1) begin m_phase = 1; m_pcnt = 0; end
         else m_pcnt++;
      1: if (acc) begin
           if (m_icnt == INITN - 1) m_phase = 2; else m_icnt++;
         end
      default: begin
        tk = (m_tcnt == IVAL_EXP - 1);
        m_tcnt = tk ? 0 : m_tcnt + 1;
        if (tk) m_pend++;
        if (acc) m_pend--;
        if (m_pend > MAXP) m_pend = MAXP;
      end
    endcase
  endtask

  task automatic compare();
    chk("R5/R6 ref_req", int'(req), int'(m_req()));
    chk("R3 ready", int'(rdy), int'(m_phase == 2));
    chk("R7 ref_row", int'(row), m_row);
    chk("R8 ref_cbr", int'(cbr), int'(!style));
  endtask

  // one cycle: drive at the falling edge, model at the rising edge, compare at next fall
  task automatic cyc(input bit g, input bit s);
    grant = g; style = s;
    @(posedge clk);
    m_step(g, s);
    @(negedge clk);
    since_rel++;
    if (req && first_req < 0) first_req = since_rel;
    compare();
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int acc_cnt;
    rst_n = 1'b0; grant = 1'b0; style = 1'b1;
    first_req = -1; since_rel = 0; ras_acc = 0;
    m_reset();
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 ref_req in reset", int'(req), 0);
    chk("R9 ready in reset", int'(rdy), 0);
    chk("R9 ref_row in reset", int'(row), 0);
    rst_n = 1'b1;

    // R1: pause with random grants, which must be ignored
    for (int i = 0; i < PAUSE_EXP; i++) cyc(rnd(), rnd());
    chk("R1 pause length", first_req, PAUSE_EXP);
    chk("R1 row untouched by pause grants", int'(row), 0);

    // R2: initialization burst with mixed styles and gaps
    for (int i = 0; i < 400 && !rdy; i++) cyc(rnd(), rnd());
    chk("R2 R3 ready after init burst", int'(rdy), 1);

    // R4 R7: prompt service, RAS-only, enough to wrap the row counter
    for (int i = 0; i < 20 * IVAL_EXP; i++) cyc(1'b1, 1'b1);
    chk("R7 row wrap", int'(row), ras_acc % ROWS);

    // R5: random grants and styles
    for (int i = 0; i < 3000; i++) cyc(rnd(), rnd());

    // R6: starve the scheduler, then drain the backlog
    for (int i = 0; i < 5 * IVAL_EXP; i++) cyc(1'b0, 1'b0);
    while (m_tcnt != 10) cyc(1'b0, 1'b1);
    chk("R6 pending saturated", m_pend, MAXP);
    acc_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      if (req) acc_cnt++;
      cyc(1'b1, 1'b1);
    end
    chk("R6 backlog drained in grants", acc_cnt, MAXP);
    chk("R6 request low after drain", int'(req), 0);

    // R8 R4: CAS-before-RAS service, row must hold
    acc_cnt = int'(row);
    for (int i = 0; i < 3 * IVAL_EXP; i++) cyc(1'b1, 1'b0);
    chk("R7 row held in CBR", int'(row), acc_cnt);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule